// File: doc/BRIEF.md
# Two-Level Page Translator with Associative Translation Buffer

This block turns a 32-bit logical address into a physical address. The low 12 bits pass through unchanged as the offset inside a 4 KB page. The upper 20 bits are the page number. A small fully associative translation buffer is searched first. On a hit, the frame number comes straight from the buffer and no table memory is touched. On a miss, the block walks a two-level page table held in an attached memory. The top 10 bits of the address select an entry in the outer table, and that entry gives the base of an inner table. The next 10 bits select the inner entry, and that entry holds the frame number. A successful walk refills the buffer.

Requests enter on a valid/ready port and results leave on a valid/ready port. Only one translation is in flight at a time. The request port drops ready from the cycle it accepts an address until the response has been taken. A response is held, unchanged, for as long as its consumer keeps `rsp_ready` low. The table memory has a simple synchronous read port: data appears on `tbl_rd_data` in the cycle after `tbl_rd_en` is high. Every table entry is 32 bits. Bits 31:12 hold a frame or table base and bit 0 is the valid flag. `root_base` supplies the 4 KB-aligned base of the outer table. A one-cycle `flush` pulse empties the buffer.

Top module: `vpage_xlate`

## Requirements
- R1: Table reads are word addresses. The outer entry is read at {root_base[31:12], va[31:22], 2'b00}. The inner entry is read at {outer_entry[31:12], va[21:12], 2'b00}. The outer read always comes first.
- R2: On a buffer hit, rsp_paddr is {buffered frame, va[11:0]} with rsp_fault low. No table read is made, and rsp_valid rises two cycles after the accepting edge.
- R3: On a miss with valid entries at both levels, exactly two table reads are made. rsp_paddr is {inner_entry[31:12], va[11:0]}, and rsp_valid rises four cycles after the accepting edge.
- R4: Bit 0 of a table entry is its valid flag (1 = valid). An invalid outer entry ends the walk after one read, with rsp_fault high and rsp_valid three cycles after acceptance. An invalid inner entry ends it after two reads, with rsp_valid four cycles after acceptance. A fault response carries rsp_paddr = 0.
- R5: Each successful walk writes its page/frame pair into the buffer. Slots are replaced in round-robin order starting at slot 0. A faulting walk writes nothing and does not advance the replacement order.
- R6: A flush pulse empties every buffer entry in one cycle, so the next access to any page misses. If a flush and a refill fall in the same cycle, the flush wins.
- R7: req_ready is high only while no translation is in progress or awaiting pickup. It is never high together with rsp_valid.
- R8: While rsp_valid is high and rsp_ready is low, rsp_valid, rsp_paddr and rsp_fault hold their values.
- R9: After reset, req_ready = 1, rsp_valid = 0 and tbl_rd_en = 0, and the buffer is empty, so the first access misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Logical address offered |
| req_ready | output | 1 | Block can accept an address |
| req_vaddr | input | 32 | Logical address |
| rsp_valid | output | 1 | Translation result available |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_paddr | output | 32 | Physical address (0 on fault) |
| rsp_fault | output | 1 | Walk hit an invalid entry |
| tbl_rd_en | output | 1 | Table memory read strobe |
| tbl_rd_addr | output | 32 | Table memory byte address |
| tbl_rd_data | input | 32 | Table entry, one cycle after the strobe |
| root_base | input | 32 | Outer table base (bits 31:12 used) |
| flush | input | 1 | Empty the translation buffer |

## Verification
A stale or corrupted buffer slot shows up on the very next response to that page. The physical address can be wrong. The read count can be wrong too, either zero where two were due or two where zero were due. The response latency shifts between two and four cycles. A slip in the round-robin pointer only shows up after the buffer wraps, when the wrong page is evicted. For that reason the stimulus fills the buffer past capacity and then revisits both the evicted page and the surviving pages. A mistake in the walk state shows up within one response as a wrong read address, a wrong read count or a missing fault.

// File: rtl/xlate_pkg.sv
`timescale 1ns/1ps
package xlate_pkg;
  localparam int VA_W   = 32;
  localparam int OFF_W  = 12;
  localparam int IDX_W  = 10;
  localparam int VPN_W  = 2 * IDX_W;
  localparam int PFN_W  = VA_W - OFF_W;
  localparam int PTE_W  = 32;
  localparam int P2_LSB = OFF_W;
  localparam int P1_LSB = OFF_W + IDX_W;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_LOOK  = 3'd1,
    ST_OUTER = 3'd2,
    ST_INNER = 3'd3,
    ST_RESP  = 3'd4
  } walk_state_t;

  function automatic logic [VA_W-1:0] entry_addr(input logic [PFN_W-1:0] base,
                                                 input logic [IDX_W-1:0] idx);
    return {base, idx, 2'b00};
  endfunction
endpackage

// File: rtl/xlate_tlb.sv
`timescale 1ns/1ps
module xlate_tlb #(
  parameter int ENTRIES = 4,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             lk_hit,
  output logic [PFN_W-1:0] lk_pfn,
  input  logic             fill_en,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PFN_W-1:0] fill_pfn
);
  localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(ENTRIES - 1);

  logic [ENTRIES-1:0] vld_q;
  logic [VPN_W-1:0]   tag_q [ENTRIES];
  logic [PFN_W-1:0]   pfn_q [ENTRIES];
  logic [ENTRIES-1:0] match;
  logic [PTR_W-1:0]   ptr_q;
  logic               do_fill;

  assign do_fill = fill_en && !flush;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    assign match[g] = vld_q[g] && (tag_q[g] == lk_vpn);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld_q[g] <= 1'b0;
        tag_q[g] <= '0;
        pfn_q[g] <= '0;
      end else if (flush) begin
        vld_q[g] <= 1'b0;
      end else if (do_fill && (ptr_q == PTR_W'(g))) begin
        vld_q[g] <= 1'b1;
        tag_q[g] <= fill_vpn;
        pfn_q[g] <= fill_pfn;
      end
    end
  end

  always_comb begin
    lk_pfn = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match[i]) lk_pfn = lk_pfn | pfn_q[i];
    end
  end

  assign lk_hit = |match;

  always_ff @(posedge clk) begin
    if (!rst_n)       ptr_q <= '0;
    else if (do_fill) ptr_q <= (ptr_q == PTR_LAST) ? '0 : ptr_q + 1'b1;
  end

  // R5: refills only happen on misses, so a page never sits in two slots
  assert_unique_slot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match));

  // R6: one flush cycle leaves no entry able to hit
  assert_flush_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !lk_hit);
endmodule

// File: rtl/xlate_walker.sv
`timescale 1ns/1ps
module xlate_walker
  import xlate_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_vaddr,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [VA_W-1:0]  rsp_paddr,
  output logic             rsp_fault,
  output logic             tbl_rd_en,
  output logic [VA_W-1:0]  tbl_rd_addr,
  input  logic [PTE_W-1:0] tbl_rd_data,
  input  logic [VA_W-1:0]  root_base,
  output logic [VPN_W-1:0] lk_vpn,
  input  logic             lk_hit,
  input  logic [PFN_W-1:0] lk_pfn,
  output logic             fill_en,
  output logic [VPN_W-1:0] fill_vpn,
  output logic [PFN_W-1:0] fill_pfn
);
  walk_state_t      state_q, state_d;
  logic [VA_W-1:0]  vaddr_q, vaddr_d;
  logic [VA_W-1:0]  paddr_q, paddr_d;
  logic             fault_q, fault_d;
  logic [IDX_W-1:0] p1, p2;
  logic [OFF_W-1:0] off;

  assign p1  = vaddr_q[P1_LSB +: IDX_W];
  assign p2  = vaddr_q[P2_LSB +: IDX_W];
  assign off = vaddr_q[OFF_W-1:0];

  assign lk_vpn   = vaddr_q[VA_W-1:OFF_W];
  assign fill_vpn = vaddr_q[VA_W-1:OFF_W];
  assign fill_pfn = tbl_rd_data[PTE_W-1:OFF_W];

  always_comb begin
    state_d     = state_q;
    vaddr_d     = vaddr_q;
    paddr_d     = paddr_q;
    fault_d     = fault_q;
    tbl_rd_en   = 1'b0;
    tbl_rd_addr = '0;
    fill_en     = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          vaddr_d = req_vaddr;
          state_d = ST_LOOK;
        end
      end
      ST_LOOK: begin
        if (lk_hit) begin
          paddr_d = {lk_pfn, off};
          fault_d = 1'b0;
          state_d = ST_RESP;
        end else begin
          tbl_rd_en   = 1'b1;
          tbl_rd_addr = entry_addr(root_base[VA_W-1:OFF_W], p1);
          state_d     = ST_OUTER;
        end
      end
      ST_OUTER: begin
        if (!tbl_rd_data[0]) begin
          paddr_d = '0;
          fault_d = 1'b1;
          state_d = ST_RESP;
        end else begin
          tbl_rd_en   = 1'b1;
          tbl_rd_addr = entry_addr(tbl_rd_data[PTE_W-1:OFF_W], p2);
          state_d     = ST_INNER;
        end
      end
      ST_INNER: begin
        if (!tbl_rd_data[0]) begin
          paddr_d = '0;
          fault_d = 1'b1;
        end else begin
          paddr_d = {tbl_rd_data[PTE_W-1:OFF_W], off};
          fault_d = 1'b0;
          fill_en = 1'b1;
        end
        state_d = ST_RESP;
      end
      ST_RESP: begin
        if (rsp_ready) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      vaddr_q <= '0;
      paddr_q <= '0;
      fault_q <= 1'b0;
    end else begin
      state_q <= state_d;
      vaddr_q <= vaddr_d;
      paddr_q <= paddr_d;
      fault_q <= fault_d;
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign rsp_valid = (state_q == ST_RESP);
  assign rsp_paddr = paddr_q;
  assign rsp_fault = fault_q;

  // R7: never accepting while a result is pending
  assert_single_txn_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_ready && rsp_valid));

  // R8: a stalled response keeps its contents
  assert_rsp_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault)));

  // R4: fault responses carry a zero address
  assert_fault_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_paddr == '0));

  // R3: a walk makes at most two back-to-back reads
  assert_two_reads_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tbl_rd_en && $past(tbl_rd_en)) |=> !tbl_rd_en);

  // R2: a hit in the lookup cycle never touches table memory
  assert_hit_noread_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LOOK && lk_hit) |-> !tbl_rd_en);
endmodule

// File: rtl/vpage_xlate.sv
`timescale 1ns/1ps
module vpage_xlate #(
  parameter int TLB_ENTRIES = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_vaddr,
  output logic        rsp_valid,
  input  logic        rsp_ready,
  output logic [31:0] rsp_paddr,
  output logic        rsp_fault,
  output logic        tbl_rd_en,
  output logic [31:0] tbl_rd_addr,
  input  logic [31:0] tbl_rd_data,
  input  logic [31:0] root_base,
  input  logic        flush
);
  import xlate_pkg::*;

  logic [VPN_W-1:0] lk_vpn;
  logic             lk_hit;
  logic [PFN_W-1:0] lk_pfn;
  logic             fill_en;
  logic [VPN_W-1:0] fill_vpn;
  logic [PFN_W-1:0] fill_pfn;

  xlate_walker u_walker (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_vaddr  (req_vaddr),
    .rsp_valid  (rsp_valid),
    .rsp_ready  (rsp_ready),
    .rsp_paddr  (rsp_paddr),
    .rsp_fault  (rsp_fault),
    .tbl_rd_en  (tbl_rd_en),
    .tbl_rd_addr(tbl_rd_addr),
    .tbl_rd_data(tbl_rd_data),
    .root_base  (root_base),
    .lk_vpn     (lk_vpn),
    .lk_hit     (lk_hit),
    .lk_pfn     (lk_pfn),
    .fill_en    (fill_en),
    .fill_vpn   (fill_vpn),
    .fill_pfn   (fill_pfn)
  );

  xlate_tlb #(
    .ENTRIES(TLB_ENTRIES),
    .VPN_W  (VPN_W),
    .PFN_W  (PFN_W)
  ) u_tlb (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush   (flush),
    .lk_vpn  (lk_vpn),
    .lk_hit  (lk_hit),
    .lk_pfn  (lk_pfn),
    .fill_en (fill_en),
    .fill_vpn(fill_vpn),
    .fill_pfn(fill_pfn)
  );
endmodule

// File: tb/vpage_xlate_bench.sv
`timescale 1ns/1ps
module vpage_xlate_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_paddr;
  logic        rsp_fault;
  logic        tbl_rd_en;
  logic [31:0] tbl_rd_addr;
  logic [31:0] tbl_rd_data = '0;
  logic [31:0] root_base = 32'h0001_0000;
  logic        flush = 1'b0;

  int checks = 0;
  int fails  = 0;
  int rd_total = 0;
  logic [31:0] rd_log [64];
  logic [31:0] tmem [logic [31:0]];

  always #10 clk = ~clk;

  vpage_xlate u_vpage_xlate (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault), .tbl_rd_en(tbl_rd_en),
    .tbl_rd_addr(tbl_rd_addr), .tbl_rd_data(tbl_rd_data),
    .root_base(root_base), .flush(flush)
  );

  always @(posedge clk) begin
    if (tbl_rd_en) begin
      tbl_rd_data <= tmem.exists(tbl_rd_addr) ? tmem[tbl_rd_addr] : 32'h0;
      rd_log[rd_total % 64] <= tbl_rd_addr;
      rd_total <= rd_total + 1;
    end
  end

  typedef struct packed {
    logic [31:0] va;
    logic [31:0] pa;
    logic        flt;
    logic [3:0]  rds;
    logic [3:0]  lat;
  } vec_t;

  // hit: 0 reads/2 cycles; miss: 2/4; outer invalid: 1/3; inner invalid: 2/4
  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_0000, 32'h0000_5000, 1'b0, 4'd2, 4'd4},  // R9 first access misses
    '{32'h0000_0003, 32'h0000_5003, 1'b0, 4'd0, 4'd2},  // R2 hit
    '{32'h0000_1001, 32'h0000_6001, 1'b0, 4'd2, 4'd4},  // R3
    '{32'h0000_2ABC, 32'h0000_1ABC, 1'b0, 4'd2, 4'd4},  // R3
    '{32'h0000_3FFF, 32'h0000_2FFF, 1'b0, 4'd2, 4'd4},  // R3 buffer now full
    '{32'h0000_0123, 32'h0000_5123, 1'b0, 4'd0, 4'd2},  // R2
    '{32'h0040_0456, 32'hABCD_E456, 1'b0, 4'd2, 4'd4},  // R5 evicts slot 0
    '{32'h0000_0000, 32'h0000_5000, 1'b0, 4'd2, 4'd4},  // R5 evicted page misses
    '{32'h0000_2000, 32'h0000_1000, 1'b0, 4'd0, 4'd2},  // R5 survivor hits
    '{32'h0000_1777, 32'h0000_6777, 1'b0, 4'd2, 4'd4},  // R5
    '{32'h0000_5010, 32'h0000_0000, 1'b1, 4'd2, 4'd4},  // R4 inner invalid
    '{32'h0000_5010, 32'h0000_0000, 1'b1, 4'd2, 4'd4},  // R4 no refill
    '{32'h00C0_0000, 32'h0000_0000, 1'b1, 4'd1, 4'd3},  // R4 outer invalid
    '{32'h007F_F00F, 32'h1234_500F, 1'b0, 4'd2, 4'd4},  // R5 fault kept pointer
    '{32'h0000_3000, 32'h0000_2000, 1'b0, 4'd2, 4'd4},  // R5
    '{32'h0040_0001, 32'hABCD_E001, 1'b0, 4'd2, 4'd4},  // R5
    '{32'h007F_FFFF, 32'h1234_5FFF, 1'b0, 4'd0, 4'd2}   // R2
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic xlate(input logic [31:0] va, output logic [31:0] pa,
                       output logic flt, output int rds, output int lat);
    int start;
    @(negedge clk);
    start = rd_total;
    req_valid = 1'b1;
    req_vaddr = va;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!rsp_valid && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    pa  = rsp_paddr;
    flt = rsp_fault;
    rds = rd_total - start;
    while (!rsp_ready) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] pa, pa0;
    logic        flt;
    int          rds, lat, s;
    tmem[32'h0001_0000] = 32'h0002_0001;
    tmem[32'h0001_0004] = 32'h0003_0001;
    tmem[32'h0002_0000] = 32'h0000_5001;
    tmem[32'h0002_0004] = 32'h0000_6001;
    tmem[32'h0002_0008] = 32'h0000_1001;
    tmem[32'h0002_000C] = 32'h0000_2001;
    tmem[32'h0002_0014] = 32'h0000_7000;
    tmem[32'h0003_0000] = 32'hABCD_E001;
    tmem[32'h0003_0FFC] = 32'h1234_5001;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 req_ready", {31'b0, req_ready}, 32'd1);
    chk("R9 rsp_valid", {31'b0, rsp_valid}, 32'd0);
    chk("R9 tbl_rd_en", {31'b0, tbl_rd_en}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      xlate(VECS[i].va, pa, flt, rds, lat);
      chk($sformatf("R2/R3/R4/R5 vec%0d paddr", i), pa, VECS[i].pa);
      chk($sformatf("R4 vec%0d fault", i), {31'b0, flt}, {31'b0, VECS[i].flt});
      chk($sformatf("R2/R3 vec%0d reads", i), rds, {28'b0, VECS[i].rds});
      chk($sformatf("R2/R3 vec%0d latency", i), lat, {28'b0, VECS[i].lat});
    end

    // R6: page 1 is buffered, flush forces a fresh walk
    xlate(32'h0000_1000, pa, flt, rds, lat);
    chk("R6 pre-flush hit reads", rds, 32'd0);
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    xlate(32'h0000_1000, pa, flt, rds, lat);
    chk("R6 post-flush reads", rds, 32'd2);
    chk("R6 post-flush paddr", pa, 32'h0000_6000);

    // R1: read addresses and order for p1=1, p2=0x3FF
    s = rd_total;
    xlate(32'h007F_F123, pa, flt, rds, lat);
    chk("R1 outer address", rd_log[s % 64], 32'h0001_0004);
    chk("R1 inner address", rd_log[(s + 1) % 64], 32'h0003_0FFC);
    chk("R1 paddr", pa, 32'h1234_5123);

    // R7/R8: stall the consumer
    rsp_ready = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = 32'h0000_1ABC;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R7 ready drops after accept", {31'b0, req_ready}, 32'd0);
    repeat (2) @(negedge clk);
    chk("R8 rsp_valid raised", {31'b0, rsp_valid}, 32'd1);
    pa0 = rsp_paddr;
    repeat (3) begin
      @(negedge clk);
      chk("R8 rsp_valid held", {31'b0, rsp_valid}, 32'd1);
      chk("R8 rsp_paddr held", rsp_paddr, pa0);
      chk("R7 ready low while pending", {31'b0, req_ready}, 32'd0);
    end
    chk("R8 paddr value", pa0, 32'h0000_6ABC);
    rsp_ready = 1'b1;
    @(negedge clk);
    chk("R7 ready back", {31'b0, req_ready}, 32'd1);
    chk("R7 rsp_valid cleared", {31'b0, rsp_valid}, 32'd0);

    summary();
    $finish;
  end
endmodule